// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block holds the coherence state of a write-through cache that does not allocate on writes. The cache is direct-mapped, and each line is either Valid or Invalid. The local processor issues one read or write at a time. A read that hits a Valid line with a matching tag completes without using the bus. A read that misses issues a bus read, and the line fills when the bus grants it. Every write is sent to the bus as a bus write. A write never allocates a line.

The controller also watches the shared bus, which is atomic. When another cache writes a line that this cache holds Valid, the controller invalidates that line in the cycle the snooped transaction is presented. Snooped reads cause no state change. Transactions that carry this cache's own originator ID also cause no state change. Only tags and valid bits are modelled here. The data array, the memory and the bus arbiter are outside this block.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read to any address is a miss and issues a bus read.
- R2: A read whose line is Invalid, or whose stored tag differs, raises `bus_req` with `bus_cmd_write`=0 and the line address. At the granting edge the line becomes Valid with the new tag. `cpu_done` pulses in the next cycle with `cpu_hit`=0.
- R3: A read to a Valid line with a matching tag never raises `bus_req`. `cpu_done` pulses in the cycle after acceptance with `cpu_hit`=1.
- R4: Every accepted write raises `bus_req` with `bus_cmd_write`=1 and the line address, whatever the state of the line.
- R5: A write to an Invalid line leaves it Invalid, so a following read to that address misses.
- R6: A write to a Valid line leaves it Valid, so a following read to that address hits.
- R7: A snooped write (`snoop_is_write`=1) from an originator other than `MY_ID` clears a Valid line with a matching tag at the edge where the snoop is presented. A read presented in the next cycle misses.
- R8: A snooped transaction whose `snoop_src_id` equals `MY_ID` leaves every line unchanged.
- R9: A snooped read, or a snooped write whose tag differs from the stored tag, leaves every line unchanged.
- R10: `cpu_req_ready` is high only when no request is outstanding. Each accepted request produces exactly one single-cycle `cpu_done` pulse, and `cpu_req_ready` returns high in the cycle after that pulse.
- R11: `bus_req` stays high, with `bus_cmd_write` and `bus_addr` held stable, until the cycle in which `bus_gnt` is high. It is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor presents a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | Request complete (one-cycle pulse) |
| cpu_hit | output | 1 | With cpu_done: read served from a Valid line |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Line address of the bus transaction |
| bus_gnt | input | 1 | Bus accepts the pending transaction this cycle |
| snoop_valid | input | 1 | A bus transaction is being observed |
| snoop_is_write | input | 1 | Observed transaction is a write |
| snoop_addr | input | ADDR_W | Line address of the observed transaction |
| snoop_src_id | input | ID_W | Originator ID of the observed transaction |

## Verification
The assertions check several properties on every cycle. A pending bus request stays stable until it is granted. `cpu_done` never lasts two cycles. An accepted write always reaches the bus as a write. A lookup hit on a read completes without the bus. A granted bus read completes as a miss. A remote snooped write that matches a line leaves that line cleared on the next cycle. Own-ID snoops and snooped reads leave the valid vector unchanged.

Other behaviours can only be shown by the bench's scenarios. These are the effect of a write that does not allocate, the effect of a write to a Valid line, the effect of a tag mismatch on a snooped write, and the sequence of states a line passes through as reads, writes and snoops interleave. The bench's reference model follows them cycle by cycle.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } ctl_state_e;

  localparam int DEF_ADDR_W = 12;
  localparam int DEF_LINES  = 16;
  localparam int DEF_ID_W   = 2;

endpackage

// File: rtl/wt_snoop_dir.sv
// Directory of valid bits and tags, with one lookup port for the processor,
// one lookup port for the snooper, a fill port and an invalidate port.
module wt_snoop_dir #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  output logic             sn_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inv_en,
  output logic [LINES-1:0] line_valid
);

  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             set_this;
    logic             clr_this;
    logic             vld_d;
    logic             vld_r;
    logic [TAG_W-1:0] tag_r;

    assign set_this = fill_en && (fill_idx == IDX_W'(i));
    assign clr_this = inv_en  && (sn_idx   == IDX_W'(i));

    // If a fill and an invalidation hit the same line, the invalidation wins.
    always_comb begin
      vld_d = vld_r;
      if (set_this) vld_d = 1'b1;
      if (clr_this) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_r <= 1'b0;
      else        vld_r <= vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tag_r <= '0;
      else if (set_this) tag_r <= fill_tag;
    end

    assign line_valid[i] = vld_r;
    assign tag_arr[i]    = tag_r;
  end

  assign lk_hit = line_valid[lk_idx] && (tag_arr[lk_idx] == lk_tag);
  assign sn_hit = line_valid[sn_idx] && (tag_arr[sn_idx] == sn_tag);

endmodule

// File: rtl/wt_snoop_filter.sv
// Qualifies an observed bus transaction: only a write from another
// originator that matches a held line produces an invalidation.
module wt_snoop_filter #(
  parameter int              ID_W  = 2,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input  logic            snoop_valid,
  input  logic            snoop_is_write,
  input  logic [ID_W-1:0] snoop_src_id,
  input  logic            sn_hit,
  output logic            inv_en
);

  logic remote_write;

  always_comb begin
    remote_write = snoop_valid && snoop_is_write && (snoop_src_id != MY_ID);
    inv_en       = remote_write && sn_hit;
  end

endmodule

// File: rtl/wt_snoop_seq.sv
// Processor-side sequencer: accepts one request, decides hit or bus,
// holds the bus request until grant, then reports completion.
module wt_snoop_seq
  import wt_snoop_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              lk_hit,
  input  logic              bus_gnt,
  output logic              cpu_req_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic              bus_cmd_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              fill_en
);

  ctl_state_e        state_q;
  ctl_state_e        state_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hit_q;
  logic              hit_d;
  logic              accept;
  logic              granted;

  assign accept  = (state_q == ST_IDLE) && cpu_req_valid;
  assign granted = (state_q == ST_BUS) && bus_gnt;

  always_comb begin
    state_d = state_q;
    hit_d   = hit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!cpu_req_write && lk_hit) begin
            state_d = ST_RESP;
            hit_d   = 1'b1;
          end else begin
            state_d = ST_BUS;
            hit_d   = 1'b0;
          end
        end
      end
      ST_BUS:  if (bus_gnt) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hit_q   <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      wr_q   <= cpu_req_write;
      addr_q <= cpu_req_addr;
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_done      = (state_q == ST_RESP);
  assign cpu_hit       = cpu_done && hit_q;
  assign bus_req       = (state_q == ST_BUS);
  assign bus_cmd_write = wr_q;
  assign bus_addr      = addr_q;
  assign fill_en       = granted && !wr_q;

endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
  import wt_snoop_pkg::*;
#(
  parameter int              ADDR_W = DEF_ADDR_W,
  parameter int              LINES  = DEF_LINES,
  parameter int              ID_W   = DEF_ID_W,
  parameter logic [ID_W-1:0] MY_ID  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic              bus_cmd_write,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              snoop_valid,
  input  logic              snoop_is_write,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ID_W-1:0]   snoop_src_id
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             lk_hit;
  logic             sn_hit;
  logic             inv_en;
  logic             fill_en;
  logic [LINES-1:0] line_valid;

  wt_snoop_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .lk_hit        (lk_hit),
    .bus_gnt       (bus_gnt),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .cpu_hit       (cpu_hit),
    .bus_req       (bus_req),
    .bus_cmd_write (bus_cmd_write),
    .bus_addr      (bus_addr),
    .fill_en       (fill_en)
  );

  wt_snoop_dir #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx     (cpu_req_addr[IDX_W-1:0]),
    .lk_tag     (cpu_req_addr[ADDR_W-1:IDX_W]),
    .lk_hit     (lk_hit),
    .sn_idx     (snoop_addr[IDX_W-1:0]),
    .sn_tag     (snoop_addr[ADDR_W-1:IDX_W]),
    .sn_hit     (sn_hit),
    .fill_en    (fill_en),
    .fill_idx   (bus_addr[IDX_W-1:0]),
    .fill_tag   (bus_addr[ADDR_W-1:IDX_W]),
    .inv_en     (inv_en),
    .line_valid (line_valid)
  );

  wt_snoop_filter #(.ID_W(ID_W), .MY_ID(MY_ID)) u_filt (
    .snoop_valid    (snoop_valid),
    .snoop_is_write (snoop_is_write),
    .snoop_src_id   (snoop_src_id),
    .sn_hit         (sn_hit),
    .inv_en         (inv_en)
  );

endmodule

// File: rtl/wt_snoop_chk.sv
module wt_snoop_chk #(
  parameter int              ADDR_W = 12,
  parameter int              LINES  = 16,
  parameter int              ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID  = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_write,
  input logic              cpu_req_ready,
  input logic              cpu_done,
  input logic              cpu_hit,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_cmd_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snoop_valid,
  input logic              snoop_is_write,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic [ID_W-1:0]   snoop_src_id,
  input logic              lk_hit,
  input logic              sn_hit,
  input logic              fill_en,
  input logic [LINES-1:0]  line_valid
);

  localparam int IDX_W = $clog2(LINES);

  logic [IDX_W-1:0] snoop_idx;
  assign snoop_idx = snoop_addr[IDX_W-1:0];

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_cmd_write));

  // R11
  bus_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> !bus_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done && cpu_req_ready);

  // R10
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req && !cpu_done);

  // R4
  write_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && cpu_req_write |=> bus_req && bus_cmd_write);

  // R3
  read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && !cpu_req_write && lk_hit |=> cpu_done && cpu_hit && !bus_req);

  // R2
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_cmd_write |=> cpu_done && !cpu_hit);

  // R7
  snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && snoop_is_write && (snoop_src_id != MY_ID) && sn_hit
    |=> !line_valid[$past(snoop_idx)]);

  // R8
  own_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && (snoop_src_id == MY_ID) && !fill_en |=> $stable(line_valid));

  // R9
  snoop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && !snoop_is_write && !fill_en |=> $stable(line_valid));

endmodule

bind wt_snoop_ctrl wt_snoop_chk #(
  .ADDR_W (ADDR_W),
  .LINES  (LINES),
  .ID_W   (ID_W),
  .MY_ID  (MY_ID)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_valid  (cpu_req_valid),
  .cpu_req_write  (cpu_req_write),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_done       (cpu_done),
  .cpu_hit        (cpu_hit),
  .bus_req        (bus_req),
  .bus_gnt        (bus_gnt),
  .bus_cmd_write  (bus_cmd_write),
  .bus_addr       (bus_addr),
  .snoop_valid    (snoop_valid),
  .snoop_is_write (snoop_is_write),
  .snoop_addr     (snoop_addr),
  .snoop_src_id   (snoop_src_id),
  .lk_hit         (lk_hit),
  .sn_hit         (sn_hit),
  .fill_en        (fill_en),
  .line_valid     (line_valid)
);

// File: tb/wt_snoop_ctrl_tb.sv
module wt_snoop_ctrl_tb;

  localparam int ADDR_W = 12;
  localparam int LINES  = 16;
  localparam int ID_W   = 2;
  localparam int MYID   = 0;

  logic              clk;
  logic              rst_n;
  logic              cpu_req_valid;
  logic              cpu_req_write;
  logic [ADDR_W-1:0] cpu_req_addr;
  logic              cpu_req_ready;
  logic              cpu_done;
  logic              cpu_hit;
  logic              bus_req;
  logic              bus_cmd_write;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_gnt;
  logic              snoop_valid;
  logic              snoop_is_write;
  logic [ADDR_W-1:0] snoop_addr;
  logic [ID_W-1:0]   snoop_src_id;

  int    n_cmp;
  int    n_bad;
  int    cyc;
  string scen;
  bit    done_flag;

  wt_snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_ready(cpu_req_ready),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_req(bus_req), .bus_cmd_write(bus_cmd_write), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt),
    .snoop_valid(snoop_valid), .snoop_is_write(snoop_is_write),
    .snoop_addr(snoop_addr), .snoop_src_id(snoop_src_id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model: per-line valid and tag, plus phase of the
  // one outstanding request (0 idle, 1 waiting for bus, 2 completing).
  bit m_vld [LINES];
  int m_tag [LINES];
  int m_phase;
  bit m_wr;
  int m_addr;
  bit m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_vld[k]) begin m_vld[k] = 0; m_tag[k] = 0; end
      m_phase = 0; m_wr = 0; m_addr = 0; m_hit = 0;
    end else begin
      int  si, st, ci, ct;
      bit  kill;
      si = int'(snoop_addr) % LINES;
      st = int'(snoop_addr) / LINES;
      kill = snoop_valid && snoop_is_write && (int'(snoop_src_id) != MYID)
             && m_vld[si] && (m_tag[si] == st);
      case (m_phase)
        0: if (cpu_req_valid) begin
             ci = int'(cpu_req_addr) % LINES;
             ct = int'(cpu_req_addr) / LINES;
             m_wr = cpu_req_write; m_addr = int'(cpu_req_addr);
             if (!cpu_req_write && m_vld[ci] && m_tag[ci] == ct) begin
               m_hit = 1; m_phase = 2;
             end else begin
               m_hit = 0; m_phase = 1;
             end
           end
        1: if (bus_gnt) begin
             if (!m_wr) begin
               m_vld[m_addr % LINES] = 1;
               m_tag[m_addr % LINES] = m_addr / LINES;
             end
             m_phase = 2;
           end
        default: m_phase = 0;
      endcase
      if (kill) m_vld[si] = 0;
    end
  end

  task automatic cmp(string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", scen, sig, act, exp, cyc);
    end
  endtask

  // Every cycle, away from the active edge, compare the outputs.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp("cpu_req_ready", int'(cpu_req_ready), int'(m_phase == 0));
      cmp("bus_req",       int'(bus_req),       int'(m_phase == 1));
      cmp("cpu_done",      int'(cpu_done),      int'(m_phase == 2));
      if (m_phase == 1) begin
        cmp("bus_cmd_write", int'(bus_cmd_write), int'(m_wr));
        cmp("bus_addr",      int'(bus_addr),      m_addr);
      end
      if (m_phase == 2) cmp("cpu_hit", int'(cpu_hit), int'(m_hit));
    end
  end

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  task automatic cpu_op(bit wr, int a, int dly);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = ADDR_W'(a);
    @(negedge clk);
    cpu_req_valid = 0;
    if (bus_req) begin
      repeat (dly) @(negedge clk);
      bus_gnt = 1;
      @(negedge clk);
      bus_gnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic snoop(bit wr, int id, int a);
    snoop_valid = 1; snoop_is_write = wr;
    snoop_src_id = ID_W'(id); snoop_addr = ADDR_W'(a);
    @(negedge clk);
    snoop_valid = 0;
  endtask

  // Expect a given hit result from a read, checked directly at completion.
  task automatic read_expect(int a, bit exp_hit);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = ADDR_W'(a);
    @(negedge clk);
    cpu_req_valid = 0;
    cmp("read bus use", int'(bus_req), int'(!exp_hit));
    if (bus_req) begin
      bus_gnt = 1;
      @(negedge clk);
      bus_gnt = 0;
    end
    cmp("read result", int'(cpu_hit), int'(exp_hit));
    @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; done_flag = 0; scen = "R1";
    rst_n = 0; cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0;
    bus_gnt = 0; snoop_valid = 0; snoop_is_write = 0; snoop_addr = '0;
    snoop_src_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and cold miss
    cmp("reset ready", int'(cpu_req_ready), 1);
    cmp("reset bus_req", int'(bus_req), 0);
    read_expect('h005, 0);
    // R3: hit after fill
    scen = "R3";
    read_expect('h005, 1);
    // R2: tag mismatch replaces the line
    scen = "R2";
    read_expect('h105, 0);
    read_expect('h005, 0);
    read_expect('h105, 0);
    // R4 / R6: write to Valid line goes to bus and keeps it Valid
    scen = "R4";
    cpu_op(1, 'h105, 0);
    scen = "R6";
    read_expect('h105, 1);
    // R5: write to Invalid line does not allocate
    scen = "R5";
    cpu_op(1, 'h0A7, 2);
    read_expect('h0A7, 0);
    // R7: remote write invalidates
    scen = "R7";
    snoop(1, 2, 'h0A7);
    read_expect('h0A7, 0);
    // R8: own-ID write ignored
    scen = "R8";
    snoop(1, MYID, 'h0A7);
    read_expect('h0A7, 1);
    // R9: snooped read and mismatched tag ignored
    scen = "R9";
    snoop(0, 3, 'h0A7);
    read_expect('h0A7, 1);
    snoop(1, 1, 'h1A7);
    read_expect('h0A7, 1);
    // R11: long grant wait
    scen = "R11";
    cpu_op(0, 'h333, 6);
    cpu_op(1, 'h333, 4);
    // R10: random mixed traffic, one request at a time
    scen = "R10";
    for (int n = 0; n < 400; n++) begin
      int a;
      a = ($urandom % 3) * LINES * 7 + ($urandom % LINES);
      if ($urandom % 4 == 0) snoop($urandom % 2, $urandom % 4, a);
      cpu_op($urandom % 3 == 0, a, $urandom % 3);
    end
    repeat (3) @(negedge clk);
    report();
  end

endmodule